// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a small register of parallel flops whose next contents are chosen each rising clock edge by a two-bit mode select. It can keep its value, shift toward the high-index end, shift toward the low-index end, or take a whole word from its parallel input in one edge. A separate serial input feeds each end of the register. Several instances can therefore be chained into a longer register: the top bit of one instance drives the low-end serial input of the next, and the bottom bit of the next drives the high-end serial input of the one before.

An active-low clear empties the register at once. It does not wait for the clock, and it wins over every other input. The width is a parameter with a default of 4. The parallel output comes straight from the flops.

Top module: `ushift_reg`

## Requirements
- R1: Mode, serial and parallel inputs are sampled only on the rising clock edge; changing them between edges leaves `q` unchanged until the next rising edge.
- R2: While `clr_n` is 0, `q` is all zeros from the moment it falls, whatever the mode and data inputs are, and clock edges do not change it.
- R3: With `sel` = 2'b00 (hold), `q` keeps its value across a rising edge.
- R4: With `sel` = 2'b01 (shift toward high index), `q[0]` takes `ser_right_in` and each `q[i]` for i > 0 takes the old `q[i-1]`.
- R5: With `sel` = 2'b10 (shift toward low index), `q[WIDTH-1]` takes `ser_left_in` and each `q[i]` for i < WIDTH-1 takes the old `q[i+1]`.
- R6: With `sel` = 2'b11 (load), `q` takes `par_in` bit for bit in one rising edge.
- R7: `ser_right_in` reaches only `q[0]` and only in mode 2'b01. `ser_left_in` reaches only `q[WIDTH-1]` and only in mode 2'b10. Each has no effect in any other mode.
- R8: When `clr_n` rises between clock edges, `q` stays zero until the next rising edge, and at that edge the register acts on the mode then selected.
- R9: Two instances can be chained: the first instance's `q[WIDTH-1]` drives the second's `ser_right_in`, and the second's `q[0]` drives the first's `ser_left_in`. Driven with a common `sel`, the pair behaves as one register of 2*WIDTH bits, with the first instance as the low half.
- R10: `WIDTH` sets the register length (default 4), and the last stage is `q[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous actions happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low, overrides everything |
| sel | input | 2 | Mode select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_right_in | input | 1 | Serial input entering `q[0]` on an upward shift |
| ser_left_in | input | 1 | Serial input entering `q[WIDTH-1]` on a downward shift |
| par_in | input | WIDTH | Parallel data taken on load |
| q | output | WIDTH | Register contents |

## Verification
The hardest case to reach from the ports is the clear arriving, and later leaving, partway through a clock period. In that case the register has to empty without an edge and then sit at zero across an edge it must not act on. The bench moves `clr_n` a few nanoseconds after a falling edge while a load of all ones is selected, and samples `q` before the next rising edge. It then releases the clear in the middle of a later period, sets up an upward shift at once, and expects exactly one new bit at the next edge. A chained pair run against an eight-bit reference model covers the boundary bits that pass between the two instances in both directions.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    output usr_mode_e  mode
);
    always_comb begin
        unique case (sel)
            2'b00:   mode = MODE_HOLD;
            2'b01:   mode = MODE_UP;
            2'b10:   mode = MODE_DOWN;
            default: mode = MODE_LOAD;
        endcase
    end
endmodule

// File: rtl/usr_next_state.sv
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  usr_mode_e          mode,
    input  logic [WIDTH-1:0]   cur,
    input  logic               ser_up,
    input  logic               ser_down,
    input  logic [WIDTH-1:0]   par,
    output logic [WIDTH-1:0]   nxt
);
    localparam int TOP = WIDTH - 1;

    // one mux per stage; the end stages pick up the serial inputs
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_below;
        logic from_above;
        if (i == 0) begin : g_low_end
            assign from_below = ser_up;
        end else begin : g_low_mid
            assign from_below = cur[i-1];
        end
        if (i == TOP) begin : g_high_end
            assign from_above = ser_down;
        end else begin : g_high_mid
            assign from_above = cur[i+1];
        end
        always_comb begin
            unique case (mode)
                MODE_HOLD: nxt[i] = cur[i];
                MODE_UP:   nxt[i] = from_below;
                MODE_DOWN: nxt[i] = from_above;
                default:   nxt[i] = par[i];
            endcase
        end
    end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } reg_state_t;

    reg_state_t       state_d, state_q;
    usr_mode_e        mode;
    logic [WIDTH-1:0] nxt_bits;

    usr_mode_dec u_dec (
        .sel  (sel),
        .mode (mode)
    );

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .mode     (mode),
        .cur      (state_q.bits),
        .ser_up   (ser_right_in),
        .ser_down (ser_left_in),
        .par      (par_in),
        .nxt      (nxt_bits)
    );

    always_comb begin
        state_d      = state_q;
        state_d.bits = nxt_bits;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q = state_q.bits;

    // R2
    clear_zero_chk: assert property (@(posedge clk) !clr_n |-> (q == '0));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b00) |=> (q == $past(q)));

    // R4
    up_shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b01) |=> (q[0] == $past(ser_right_in)) && (q[TOP:1] == $past(q[TOP-1:0])));

    // R5
    down_shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b10) |=> (q[TOP] == $past(ser_left_in)) && (q[TOP-1:0] == $past(q[TOP:1])));

    // R6
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |=> (q == $past(par_in)));
endmodule

// File: tb/ushift_reg_tb.sv
module ushift_reg_tb;
    localparam int W  = 4;
    localparam int W2 = 2 * W;

    logic          clk = 1'b0;
    logic          clr_n = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic          sr_in = 1'b0;
    logic          sl_in = 1'b0;
    logic [W2-1:0] par8 = '0;
    logic [W-1:0]  q_lo, q_hi;
    logic [W2-1:0] model = '0;
    logic [W2-1:0] q_all;

    int checks = 0;
    int fails  = 0;

    logic [W2-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    assign q_all = {q_hi, q_lo};

    // R9, R10: two default-width instances chained into one 8-bit register
    ushift_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .clr_n(clr_n), .sel(sel),
        .ser_right_in(sr_in), .ser_left_in(q_hi[0]),
        .par_in(par8[W-1:0]), .q(q_lo)
    );
    ushift_reg #(.WIDTH(W)) u_ext (
        .clk(clk), .clr_n(clr_n), .sel(sel),
        .ser_right_in(q_lo[W-1]), .ser_left_in(sl_in),
        .par_in(par8[W2-1:W]), .q(q_hi)
    );

    task automatic check(input string tag, input logic [W2-1:0] act, input logic [W2-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // sets inputs now and queues the value expected after the next edge
    task automatic apply(input logic [1:0] s, input logic r, input logic l,
                         input logic [W2-1:0] p, input string tag);
        sel = s; sr_in = r; sl_in = l; par8 = p;
        case (s)
            2'b00: model = model;
            2'b01: model = {model[W2-2:0], r};
            2'b10: model = {l, model[W2-1:1]};
            default: model = p;
        endcase
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic drive(input logic [1:0] s, input logic r, input logic l,
                         input logic [W2-1:0] p, input string tag);
        @(negedge clk);
        apply(s, r, l, p, tag);
    endtask

    // monitor: compares after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [W2-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, q_all, e);
        end
    end

    initial begin
        #4_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W2-1:0] held;
        // R2: reset state, inputs set to load all ones
        sel = 2'b11; par8 = '1;
        repeat (2) @(posedge clk);
        #3;
        check("R2 reset state", q_all, '0);

        // R8: release mid-cycle, stays zero, then acts at next edge
        @(negedge clk);
        #3 clr_n = 1'b1;
        #1 check("R8 zero after release", q_all, '0);
        model = '0;
        apply(2'b11, 1'b0, 1'b0, 8'hA5, "R8 acts at first edge");

        drive(2'b11, 1'b1, 1'b1, 8'h3C, "R6 load");
        // R1: no change before the edge
        #1 check("R1 no change between edges", q_all, 8'hA5);
        drive(2'b00, 1'b1, 1'b1, 8'hFF, "R3 hold");
        drive(2'b00, 1'b1, 1'b1, 8'h00, "R7 serial ignored in hold");
        drive(2'b01, 1'b1, 1'b0, 8'h00, "R4 shift up");
        drive(2'b01, 1'b0, 1'b1, 8'h00, "R4 R9 shift up across halves");
        drive(2'b01, 1'b1, 1'b1, 8'hFF, "R7 left input ignored on up shift");
        drive(2'b10, 1'b1, 1'b0, 8'h00, "R5 R10 shift down");
        drive(2'b10, 1'b0, 1'b1, 8'hFF, "R5 R9 shift down across halves");
        drive(2'b10, 1'b0, 1'b1, 8'h00, "R7 right input ignored on down shift");
        drive(2'b11, 1'b1, 1'b1, 8'h81, "R6 R7 load ignores serial");
        drive(2'b01, 1'b0, 1'b0, 8'h00, "R9 top of low half moves up");
        drive(2'b10, 1'b0, 1'b0, 8'h00, "R9 bottom of high half moves down");

        // R2: clear in the middle of a period overrides a load of all ones
        drive(2'b11, 1'b0, 1'b0, 8'hC3, "R6 load before clear");
        @(negedge clk);
        sel = 2'b11; par8 = '1; sr_in = 1'b1; sl_in = 1'b1;
        #3 clr_n = 1'b0;
        #1 check("R2 immediate clear", q_all, '0);
        @(posedge clk);
        #2 check("R2 edge ignored while clear", q_all, '0);
        @(negedge clk);
        #3 clr_n = 1'b1;
        #1 check("R8 still zero after release", q_all, '0);
        model = '0;
        apply(2'b01, 1'b1, 1'b0, 8'hFF, "R8 one up shift after release");

        // mixed patterns
        for (int k = 0; k < 60; k++) begin
            logic [1:0] s;
            s = 2'(($urandom % 4));
            drive(s, 1'($urandom), 1'($urandom), 8'($urandom),
                  (s == 2'b00) ? "R3 mixed hold" :
                  (s == 2'b01) ? "R4 mixed up" :
                  (s == 2'b10) ? "R5 mixed down" : "R6 mixed load");
        end
        held = model;
        drive(2'b00, 1'b1, 1'b1, ~held, "R3 final hold");
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule